// File: doc/BRIEF.md
# Smart Card Contact Clock Controller

This block builds the clock that is driven onto a smart card contact. It works from one master clock that runs at twice the crystal frequency. It can deliver the crystal rate, that rate divided by 2, 4 or 8, or the internal oscillator divided by two. The internal oscillator arrives as an asynchronous level input and passes through a two-stage synchronizer. A new rate takes effect only on a falling edge of the card clock, so a rate change never produces a runt phase. A stop request parks the clock at a chosen level. In synchronous-card mode, a software bit drives the clock level directly.

The generated level goes to one of three card ports, A, B or AUX, chosen by a one-hot select. Ports that are not selected stay low. The block also gives a one-cycle tick on every rising edge of the delivered clock, for a separate elementary-time-unit counter. In synchronous-card mode there is a one-bit data path. In transmit, a valid/ready byte stream is accepted and its least significant bit drives the card I/O line. In receive, the I/O line is sampled into bit 0 of a receive word.

The transmit stream has these back-pressure rules. `tx_ready_o` is high only while the block is out of soft reset and is in synchronous transmit mode. A byte is taken on a cycle where `tx_valid_i` and `tx_ready_o` are both high. While ready is low, the producer keeps the byte waiting and nothing changes on the I/O line.

Top module: `card_clk_ctl`

## Requirements
- R1: With `rate_sel_i` at 000, 001, 010 or 011 and no stop request, each card clock phase lasts exactly 1, 2, 4 or 8 master clock cycles. This is the crystal rate, /2, /4 and /8, with the master clock at twice the crystal rate.
- R2: With any `rate_sel_i` code whose bit 2 is 1, each steady card clock phase lasts exactly one internal oscillator period, which gives the oscillator divided by two.
- R3: A new rate is applied only on a falling edge of the card clock. No phase after a rate change is shorter than the smaller of the old and new half-periods, and the phases settle at the new half-period.
- R4: While `stop_req_i` is 1, the card clock halts on the next natural edge that reaches the requested level and holds that level. The level is low when `stop_high_i` is 0 and high when it is 1. A rate change requested in the same cycle as the stop is still taken on the next falling edge.
- R5: After `stop_req_i` returns to 0, the clock leaves the parked level with no shortened phase. For the crystal-derived rates, every later phase is exactly the current half-period.
- R6: With `sync_mode_i` at 1, the selected port copies `sync_clk_i` with a latency of one master clock cycle.
- R7: `card_sel_i` is one-hot: bit 0 (001) drives port A, which is port_clk_o[0]; bit 1 (010) drives port B, which is port_clk_o[1]; bit 2 (100) drives the AUX port, which is port_clk_o[2]. A value of 000, or any value with more than one bit set, selects no port. Every port that is not selected holds its clock low.
- R8: While `ctl_rst_n_i` is 0, every port clock and the tick are 0. The clock generator returns to its reset state, and the synchronous data path registers are cleared.
- R9: `etu_tick_o` is a one-cycle pulse that is 1 in exactly the cycles where the delivered port clock has just risen.
- R10: In synchronous transmit mode (`sync_mode_i` = 1 and `xfer_dir_i` = 1), `tx_ready_o` and `io_oe_o` are 1. An accepted byte drives its bit 0 on `io_out_o` from the next cycle. In any other mode, ready and output enable are 0 and `io_out_o` keeps its value.
- R11: In synchronous receive mode (`sync_mode_i` = 1 and `xfer_dir_i` = 0), bit 0 of `rx_data_o` shows `io_in_i` one cycle later, and the upper bits read 0. In any other mode, `rx_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the crystal frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_rst_n_i | input | 1 | Active-low soft reset of the clock control and the data path |
| osc_i | input | 1 | Internal oscillator level, asynchronous |
| rate_sel_i | input | 3 | Rate code: divider or oscillator choice |
| stop_req_i | input | 1 | Clock stop request |
| stop_high_i | input | 1 | Parked level during a stop (1 = high) |
| sync_mode_i | input | 1 | Synchronous-card mode enable |
| sync_clk_i | input | 1 | Software clock level used in synchronous-card mode |
| card_sel_i | input | 3 | One-hot card port select |
| port_clk_o | output | 3 | Clock for each card port (A, B, AUX) |
| etu_tick_o | output | 1 | One-cycle pulse on each rising edge of the delivered clock |
| xfer_dir_i | input | 1 | Synchronous data direction (1 = transmit) |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit byte ready |
| tx_data_i | input | 8 | Transmit byte; bit 0 goes to the I/O line |
| io_out_o | output | 1 | Card I/O line drive value |
| io_oe_o | output | 1 | Card I/O line output enable |
| io_in_i | input | 1 | Card I/O line sampled level |
| rx_data_o | output | 8 | Receive word; bit 0 holds the I/O line level |

## Verification
A stop request and a rate change can both land on the same falling edge of the card clock. That edge then parks the clock low and latches the new rate at once. The bench provokes this by raising a low-level stop and changing the rate code in the same cycle while the clock runs at a slower rate. It then holds the parked level and measures the phases after release, which must be exactly the new half-period. Phase lengths come from counting master cycles between level changes of the delivered clock. They are compared with half-periods computed from the rate code, and with the oscillator period the bench itself generates.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int CARD_PORTS = 3;
  localparam int RATE_W     = 3;
  localparam int DATA_W     = 8;

  typedef enum int {
    PORT_A   = 0,
    PORT_B   = 1,
    PORT_AUX = 2
  } port_idx_e;

  typedef logic [RATE_W-1:0] rate_code_t;
endpackage

// File: rtl/scc_rate_gen.sv
module scc_rate_gen
  import scc_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       osc_i,
  input  rate_code_t rate_i,
  input  logic       stop_i,
  input  logic       stop_lvl_i,
  output logic       lvl_o
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] osc_sync_q;
  logic                   osc_last_q;
  logic                   osc_rise;
  rate_code_t             cur_rate_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       half_m1;
  logic                   lvl_q;
  logic                   halted_q;
  logic                   armed_q;
  logic                   ev;

  // two-stage synchronizer plus edge detect for the oscillator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_sync_q <= '0;
      osc_last_q <= 1'b0;
    end else begin
      osc_sync_q <= {osc_sync_q[SYNC_STAGES-2:0], osc_i};
      osc_last_q <= osc_sync_q[SYNC_MSB];
    end
  end

  assign osc_rise = osc_sync_q[SYNC_MSB] & ~osc_last_q;
  assign half_m1  = (CNT_W'(1) << cur_rate_q[1:0]) - CNT_W'(1);

  always_comb begin
    if (cur_rate_q[RATE_W-1]) ev = osc_rise & armed_q;
    else                      ev = (cnt_q == half_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_rate_q <= '0;
      cnt_q      <= '0;
      lvl_q      <= 1'b0;
      halted_q   <= 1'b0;
      armed_q    <= 1'b0;
    end else if (clr) begin
      cur_rate_q <= '0;
      cnt_q      <= '0;
      lvl_q      <= 1'b0;
      halted_q   <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      if (cur_rate_q[RATE_W-1] && osc_rise) armed_q <= 1'b1;
      if (halted_q) begin
        if (!stop_i) begin
          halted_q <= 1'b0;
          cnt_q    <= '0;
          armed_q  <= 1'b0;
        end
      end else begin
        cnt_q <= ev ? '0 : cnt_q + CNT_W'(1);
        if (ev) begin
          lvl_q <= ~lvl_q;
          if (stop_i && ((~lvl_q) == stop_lvl_i)) halted_q <= 1'b1;
          if (lvl_q) begin
            // falling edge: the only point where a new rate is adopted
            cur_rate_q <= rate_i;
            if (!(cur_rate_q[RATE_W-1] && rate_i[RATE_W-1])) armed_q <= 1'b0;
          end
        end
      end
    end
  end

  assign lvl_o = lvl_q;

  assert_rate_at_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_rate_q) |-> !lvl_q);

  assert_halt_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_q) |-> (lvl_q == $past(stop_lvl_i)));

  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && stop_i && !clr) |=> $stable(lvl_q));
endmodule

// File: rtl/scc_port_route.sv
module scc_port_route
  import scc_pkg::*;
#(
  parameter int PORTS = CARD_PORTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             lvl_i,
  input  logic [PORTS-1:0] card_i,
  output logic [PORTS-1:0] port_o,
  output logic             tick_o
);
  logic             card_ok;
  logic [PORTS-1:0] port_d;
  logic [PORTS-1:0] port_q;
  logic             tick_q;

  always_comb card_ok = ($countones(card_i) == 1);

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    assign port_d[g] = ~clr & lvl_i & card_ok & card_i[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) port_q[g] <= 1'b0;
      else        port_q[g] <= port_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= (|port_d) & ~(|port_q);
  end

  assign port_o = port_q;
  assign tick_o = tick_q;

  assert_onehot_ports_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_q));

  assert_quiet_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (port_q == '0) && !tick_q);

  assert_tick_on_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> ((|port_q) && !$past(|port_q)));
endmodule

// File: rtl/scc_sync_io.sv
module scc_sync_io
  import scc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          sync_mode_i,
  input  logic          dir_tx_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  input  logic [DW-1:0] tx_data_i,
  output logic          io_out_o,
  output logic          io_oe_o,
  input  logic          io_in_i,
  output logic [DW-1:0] rx_data_o
);
  logic io_q;
  logic rx_bit_q;
  logic tx_mode;
  logic rx_mode;

  assign tx_mode = ~clr & sync_mode_i & dir_tx_i;
  assign rx_mode = ~clr & sync_mode_i & ~dir_tx_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q     <= 1'b0;
      rx_bit_q <= 1'b0;
    end else if (clr) begin
      io_q     <= 1'b0;
      rx_bit_q <= 1'b0;
    end else begin
      if (tx_mode && tx_valid_i) io_q <= tx_data_i[0];
      if (rx_mode)               rx_bit_q <= io_in_i;
    end
  end

  assign tx_ready_o = tx_mode;
  assign io_oe_o    = tx_mode;
  assign io_out_o   = io_q;
  assign rx_data_o  = {{(DW-1){1'b0}}, rx_bit_q};

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(tx_valid_i && tx_ready_o)) |=> $stable(io_out_o));
endmodule

// File: rtl/card_clk_ctl.sv
module card_clk_ctl
  import scc_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_rst_n_i,
  input  logic                  osc_i,
  input  logic [RATE_W-1:0]     rate_sel_i,
  input  logic                  stop_req_i,
  input  logic                  stop_high_i,
  input  logic                  sync_mode_i,
  input  logic                  sync_clk_i,
  input  logic [CARD_PORTS-1:0] card_sel_i,
  output logic [CARD_PORTS-1:0] port_clk_o,
  output logic                  etu_tick_o,
  input  logic                  xfer_dir_i,
  input  logic                  tx_valid_i,
  output logic                  tx_ready_o,
  input  logic [DATA_W-1:0]     tx_data_i,
  output logic                  io_out_o,
  output logic                  io_oe_o,
  input  logic                  io_in_i,
  output logic [DATA_W-1:0]     rx_data_o
);
  logic clr;
  logic gen_lvl;
  logic card_lvl;

  assign clr = ~ctl_rst_n_i;

  scc_rate_gen #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .osc_i      (osc_i),
    .rate_i     (rate_sel_i),
    .stop_i     (stop_req_i),
    .stop_lvl_i (stop_high_i),
    .lvl_o      (gen_lvl)
  );

  assign card_lvl = sync_mode_i ? sync_clk_i : gen_lvl;

  scc_port_route #(
    .PORTS (CARD_PORTS)
  ) u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .lvl_i  (card_lvl),
    .card_i (card_sel_i),
    .port_o (port_clk_o),
    .tick_o (etu_tick_o)
  );

  scc_sync_io #(
    .DW (DATA_W)
  ) u_io (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .sync_mode_i (sync_mode_i),
    .dir_tx_i    (xfer_dir_i),
    .tx_valid_i  (tx_valid_i),
    .tx_ready_o  (tx_ready_o),
    .tx_data_i   (tx_data_i),
    .io_out_o    (io_out_o),
    .io_oe_o     (io_oe_o),
    .io_in_i     (io_in_i),
    .rx_data_o   (rx_data_o)
  );

  assert_sync_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rst_n_i && sync_mode_i && ($countones(card_sel_i) == 1))
      |=> ((|port_clk_o) == $past(sync_clk_i)));
endmodule

// File: tb/card_clk_ctl_bench.sv
module card_clk_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_HALF   = 5;
  localparam int OSC_PER    = 2 * OSC_HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_rst_n = 1'b0;
  logic       osc = 1'b0;
  logic [2:0] rate_sel = 3'b000;
  logic       stop_req = 1'b0;
  logic       stop_high = 1'b0;
  logic       sync_mode = 1'b0;
  logic       sync_clk = 1'b0;
  logic [2:0] card_sel = 3'b000;
  logic [2:0] port_clk;
  logic       etu_tick;
  logic       xfer_dir = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       io_out;
  logic       io_oe;
  logic       io_in = 1'b0;
  logic [7:0] rx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (OSC_HALF) @(negedge clk);
    osc = ~osc;
  end

  card_clk_ctl u_card_clk_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_rst_n_i(ctl_rst_n), .osc_i(osc),
    .rate_sel_i(rate_sel), .stop_req_i(stop_req), .stop_high_i(stop_high),
    .sync_mode_i(sync_mode), .sync_clk_i(sync_clk), .card_sel_i(card_sel),
    .port_clk_o(port_clk), .etu_tick_o(etu_tick), .xfer_dir_i(xfer_dir),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .io_out_o(io_out), .io_oe_o(io_oe), .io_in_i(io_in), .rx_data_o(rx_data)
  );

  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // phase tracker and tick monitor on the delivered clock
  int ph_len[64];
  int ph_n = 0;
  int run = 0;
  bit prev_any = 0;
  bit skip = 1;
  bit clear_req = 0;
  int tick_bad = 0;
  int tick_seen = 0;
  bit cur_any;

  always @(negedge clk) begin
    cur_any = |port_clk;
    if (rst_n) begin
      if (etu_tick !== (cur_any & ~prev_any)) tick_bad++;
      if (etu_tick) tick_seen++;
    end
    if (clear_req) begin
      ph_n = 0; skip = 1; clear_req = 0;
    end
    if (cur_any != prev_any) begin
      if (!skip && ph_n < 64) begin
        ph_len[ph_n] = run;
        ph_n++;
      end
      skip = 0;
      run = 1;
    end else begin
      run++;
    end
    prev_any = cur_any;
  end

  function automatic logic [2:0] code_of(input int i);
    return (i == 4) ? 3'b110 : 3'(i);
  endfunction

  function automatic int half_of(input int i);
    return (i == 4) ? OSC_PER : (1 << i);
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clear_req = 1;
    wait_n(2);
  endtask

  initial begin
    int hold_ok;
    int mn;
    int min_seen;
    bit steady;
    bit [7:0] pat;
    wait_n(3);
    // reset state
    chk(port_clk == 3'b000, "R8 reset ports", port_clk, 0);
    chk(etu_tick == 1'b0 && tx_ready == 1'b0, "R10 reset ready", tx_ready, 0);
    chk(rx_data == 8'h00 && io_out == 1'b0, "R11 reset rx", rx_data, 0);
    rst_n = 1'b1;
    wait_n(2);
    chk(port_clk == 3'b000, "R8 soft reset held", port_clk, 0);
    ctl_rst_n = 1'b1;
    card_sel = 3'b001;

    // R1 R2 R3: rate transitions across all pairs
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 5; b++) begin
        if (a != b) begin
          rate_sel = code_of(a);
          wait_n(100);
          do_clear();
          rate_sel = code_of(b);
          wait_n(170);
          mn = (half_of(a) < half_of(b)) ? half_of(a) : half_of(b);
          min_seen = 1000;
          for (int k = 0; k < ph_n; k++) if (ph_len[k] < min_seen) min_seen = ph_len[k];
          chk(ph_n >= 4 && min_seen >= mn, "R3 no runt phase", min_seen, mn);
          steady = (ph_n >= 4);
          for (int k = 1; k <= 3; k++) if (ph_n >= 4 && ph_len[ph_n-k] != half_of(b)) steady = 0;
          chk(steady, (b == 4) ? "R2 steady oscillator rate" : "R1 steady crystal rate",
              (ph_n >= 1) ? ph_len[ph_n-1] : -1, half_of(b));
        end
      end
    end

    // R2: every code with bit 2 set uses the oscillator
    for (int c = 4; c < 8; c++) begin
      rate_sel = 3'(c);
      wait_n(60);
      do_clear();
      wait_n(80);
      steady = (ph_n >= 4);
      for (int k = 1; k <= 3; k++) if (ph_n >= 4 && ph_len[ph_n-k] != OSC_PER) steady = 0;
      chk(steady, "R2 code 1xx oscillator", (ph_n >= 1) ? ph_len[ph_n-1] : -1, OSC_PER);
    end

    // R4 R5: stop low with simultaneous rate change, then stop high
    rate_sel = 3'b010;
    wait_n(40);
    for (int lv = 0; lv < 2; lv++) begin
      rate_sel = (lv == 0) ? 3'b001 : 3'b010;
      stop_high = lv[0];
      stop_req = 1'b1;
      wait_n(40);
      hold_ok = 1;
      for (int k = 0; k < 20; k++) begin
        if (port_clk[0] != lv[0]) hold_ok = 0;
        if (etu_tick) hold_ok = 0;
        wait_n(1);
      end
      chk(hold_ok == 1, "R4 parked level", port_clk[0], lv);
      do_clear();
      stop_req = 1'b0;
      wait_n(40);
      mn = (lv == 0) ? 2 : 4;
      chk(ph_n >= 2 && ph_len[0] == mn && ph_len[1] == mn, "R5 resume phases",
          (ph_n >= 1) ? ph_len[0] : -1, mn);
    end

    // R7: card select sweep at the crystal rate
    rate_sel = 3'b000;
    for (int c = 0; c < 8; c++) begin
      int chg[3];
      int ones[3];
      logic [2:0] pv;
      card_sel = 3'(c);
      wait_n(4);
      pv = port_clk;
      for (int p = 0; p < 3; p++) begin chg[p] = 0; ones[p] = 0; end
      for (int k = 0; k < 16; k++) begin
        wait_n(1);
        for (int p = 0; p < 3; p++) begin
          if (port_clk[p] != pv[p]) chg[p]++;
          if (port_clk[p]) ones[p]++;
        end
        pv = port_clk;
      end
      for (int p = 0; p < 3; p++) begin
        if (c == (1 << p))
          chk(chg[p] == 16, "R7 selected port toggles", chg[p], 16);
        else
          chk(chg[p] == 0 && ones[p] == 0, "R7 unselected port low", chg[p] + ones[p], 0);
      end
    end

    // R8: soft reset silences everything
    card_sel = 3'b001;
    wait_n(5);
    ctl_rst_n = 1'b0;
    wait_n(1);
    hold_ok = 1;
    for (int k = 0; k < 20; k++) begin
      if (port_clk != 3'b000 || etu_tick) hold_ok = 0;
      wait_n(1);
    end
    chk(hold_ok == 1, "R8 quiet in soft reset", port_clk, 0);
    ctl_rst_n = 1'b1;
    do_clear();
    wait_n(20);
    chk(ph_n > 5, "R8 runs after soft reset", ph_n, 6);

    // R6: synchronous-card mode on port B
    card_sel = 3'b010;
    sync_mode = 1'b1;
    pat = 8'b1011_0010;
    for (int k = 0; k < 8; k++) begin
      sync_clk = pat[k];
      wait_n(1);
      chk(port_clk[1] == pat[k] && port_clk[0] == 1'b0, "R6 follows software bit", port_clk[1], pat[k]);
    end

    // R10: synchronous transmit
    xfer_dir = 1'b1;
    tx_valid = 1'b1;
    tx_data = 8'h35;
    wait_n(1);
    chk(tx_ready && io_oe && io_out == 1'b1, "R10 transmit lsb one", io_out, 1);
    tx_data = 8'hA4;
    wait_n(1);
    chk(tx_ready && io_out == 1'b0, "R10 transmit lsb zero", io_out, 0);
    xfer_dir = 1'b0;
    tx_data = 8'h01;
    wait_n(2);
    chk(!tx_ready && !io_oe && io_out == 1'b0, "R10 no accept when not ready", io_out, 0);
    tx_valid = 1'b0;

    // R11: synchronous receive
    io_in = 1'b1;
    wait_n(1);
    chk(rx_data == 8'h01, "R11 receive one", rx_data, 1);
    io_in = 1'b0;
    wait_n(1);
    chk(rx_data == 8'h00, "R11 receive zero", rx_data, 0);
    sync_mode = 1'b0;
    io_in = 1'b1;
    wait_n(2);
    chk(rx_data == 8'h00, "R11 hold outside mode", rx_data, 0);

    // R9: tick against the delivered clock over the whole run
    chk(tick_bad == 0, "R9 tick matches rising edges", tick_bad, 0);
    chk(tick_seen > 0, "R9 ticks seen", tick_seen, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule